// File: doc/BRIEF.md
# Multi-port PHY interrupt aggregator

This block gathers change events from four transceiver ports into one status and enable register that all ports share, and drives a single active-low interrupt line in open-drain style. Each port tracks four conditions: a change of link state, a change of duplex mode, a change of auto-negotiation state, and a jabber error. A change is found by comparing each level input with its value from the previous clock. Status bits latch whether or not the matching enable bit is set. The interrupt is asserted while any status bit that is also enabled is set.

Software reads the status word through a simple management port. Each read clears the three change bits of every port. The jabber bit is not cleared by a read. It follows the port's jabber condition and drops on its own once the port leaves that state. The enable word sits at a second register address and is the only writable field. The two low bits of the device address select a port on the other registers of the chip, and this block ignores them: any port address inside the device reaches the shared register.

Top module: `phy_irq_hub`

## Requirements
- R1: After reset the status word and the enable word are zero, `irq_n_o` is 1 (released), and `mgmt_rdata` is zero whenever no matching read is active.
- R2: When the link, duplex or auto-negotiation input of port p toggles, status bit 4p+0, 4p+1 or 4p+2 reads 1 from the next clock on.
- R3: Status bits latch whether or not their enable bit is set. With the enable bit at 0, a set status bit leaves `irq_n_o` at 1.
- R4: `irq_n_o` is 0 exactly while some bit is 1 in both the status word and the enable word. It returns to 1 in the cycle after the last such bit clears.
- R5: A read of the status register (address STAT_REGAD, default 16) returns the current status word in the same cycle. At the next clock it clears every change bit (bit positions 4p+0 to 4p+2).
- R6: If a change event arrives in the same cycle as a clearing read, the read returns the old value and the event's bit is still 1 afterwards.
- R7: Status bit 4p+3 equals port p's jabber input delayed by one clock. Reads never clear it.
- R8: A write to register address EN_REGAD (default 21) loads the 16-bit enable word, and a read at that address returns it. A write at any other register address changes neither word.
- R9: An access responds only when the upper three device-address bits equal DEV_HI (default 3'b001). The low two bits are ignored. A non-matching read returns 0 and clears nothing, and a non-matching write has no effect.
- R10: No change event is recorded in the first clock after reset, whatever levels the inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_i | input | 4 | Link level per port |
| duplex_i | input | 4 | Duplex level per port |
| aneg_i | input | 4 | Auto-negotiation state level per port |
| jabber_i | input | 4 | Jabber condition per port |
| mgmt_rd | input | 1 | Management read strobe, one cycle per read |
| mgmt_wr | input | 1 | Management write strobe |
| mgmt_dev | input | 5 | Device address; bits [1:0] are ignored |
| mgmt_reg | input | 5 | Register address |
| mgmt_wdata | input | 16 | Write data (enable word) |
| mgmt_rdata | output | 16 | Read data, valid in the cycle of the read |
| irq_n_o | output | 1 | Active-low interrupt, 1 means released |

## Verification
Single toggles on link, duplex and auto-negotiation inputs of different ports show that each event lands in its own bit and that a read clears it. A jabber pulse held across two reads separates the self-clearing bit from the clear-on-read bits. A toggle in the same cycle as a clearing read shows that no event is lost. Masked and unmasked events, and reads at foreign and aliased device addresses, show that gating is done by the enables and that decoding ignores the port bits.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

  // Event kinds inside one port's nibble; the position is fixed by the register layout.
  localparam int EV_LINK    = 0;
  localparam int EV_DUPLEX  = 1;
  localparam int EV_ANEG    = 2;
  localparam int EV_JABBER  = 3;
  localparam int EV_PER_PORT = 4;
  localparam int CHG_KINDS  = 3;

  function automatic int stat_bit(input int port, input int kind);
    return port * EV_PER_PORT + kind;
  endfunction

  // Mask of all clear-on-read bits for a given port count (up to 16 ports).
  function automatic logic [63:0] chg_mask(input int nports);
    logic [63:0] m;
    m = '0;
    for (int p = 0; p < nports; p++) begin
      for (int k = 0; k < CHG_KINDS; k++) begin
        m[stat_bit(p, k)] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/phy_irq_edge.sv
module phy_irq_edge #(
  parameter int KINDS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             primed_i,
  input  logic [KINDS-1:0] lvl_i,
  output logic [KINDS-1:0] chg_o
);

  logic [KINDS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  // The first cycle after reset only loads prev_q, so no change is reported.
  assign chg_o = primed_i ? (lvl_i ^ prev_q) : '0;

endmodule

// File: rtl/phy_irq_stat.sv
module phy_irq_stat #(
  parameter int NPORTS = 4,
  parameter int STAT_W = 16,
  parameter logic [STAT_W-1:0] CHG_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] evt_i,
  input  logic [NPORTS-1:0] jab_i,
  input  logic              clr_i,
  output logic [STAT_W-1:0] stat_o
);
  import phy_irq_pkg::*;

  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] jab_spread;
  logic [STAT_W-1:0] keep_mask;
  logic [STAT_W-1:0] stat_nxt;

  always_comb begin
    jab_spread = '0;
    for (int p = 0; p < NPORTS; p++) begin
      jab_spread[stat_bit(p, EV_JABBER)] = jab_i[p];
    end
  end

  // A read clears the change bits. A new event in the same cycle sets its bit again.
  assign keep_mask = clr_i ? ~CHG_MASK : '1;
  assign stat_nxt  = (((stat_q & keep_mask) | evt_i) & CHG_MASK) | jab_spread;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_nxt;
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/phy_irq_mgmt.sv
module phy_irq_mgmt #(
  parameter int AW        = 5,
  parameter int SEL_W     = 2,
  parameter int DW        = 16,
  parameter logic [AW-SEL_W-1:0] DEV_HI = '0,
  parameter logic [4:0] STAT_REGAD = 5'd16,
  parameter logic [4:0] EN_REGAD   = 5'd21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] dev_i,
  input  logic [4:0]    reg_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] stat_i,
  output logic [DW-1:0] en_o,
  output logic [DW-1:0] rdata_o,
  output logic          rd_stat_hit_o,
  output logic          rd_en_hit_o,
  output logic          wr_en_hit_o
);

  logic            dev_hit;
  logic [DW-1:0]   en_q;
  logic [SEL_W-1:0] unused_port_sel;

  // The port-select bits select nothing for the shared register.
  assign unused_port_sel = dev_i[SEL_W-1:0];
  assign dev_hit         = (dev_i[AW-1:SEL_W] == DEV_HI);

  assign rd_stat_hit_o = rd_i & dev_hit & (reg_i == STAT_REGAD);
  assign rd_en_hit_o   = rd_i & dev_hit & (reg_i == EN_REGAD);
  assign wr_en_hit_o   = wr_i & dev_hit & (reg_i == EN_REGAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           en_q <= '0;
    else if (wr_en_hit_o) en_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_stat_hit_o)    rdata_o = stat_i;
    else if (rd_en_hit_o) rdata_o = en_q;
  end

  assign en_o = en_q;

endmodule

// File: rtl/phy_irq_hub.sv
module phy_irq_hub #(
  parameter int NPORTS = 4,
  parameter int AW     = 5,
  parameter logic [2:0] DEV_HI     = 3'b001,
  parameter logic [4:0] STAT_REGAD = 5'd16,
  parameter logic [4:0] EN_REGAD   = 5'd21
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NPORTS-1:0]                    link_i,
  input  logic [NPORTS-1:0]                    duplex_i,
  input  logic [NPORTS-1:0]                    aneg_i,
  input  logic [NPORTS-1:0]                    jabber_i,
  input  logic                                 mgmt_rd,
  input  logic                                 mgmt_wr,
  input  logic [AW-1:0]                        mgmt_dev,
  input  logic [4:0]                           mgmt_reg,
  input  logic [NPORTS*phy_irq_pkg::EV_PER_PORT-1:0] mgmt_wdata,
  output logic [NPORTS*phy_irq_pkg::EV_PER_PORT-1:0] mgmt_rdata,
  output logic                                 irq_n_o
);
  import phy_irq_pkg::*;

  localparam int SEL_W  = $clog2(NPORTS);
  localparam int STAT_W = NPORTS * EV_PER_PORT;
  localparam logic [STAT_W-1:0] CHG_MASK = STAT_W'(chg_mask(NPORTS));

  // Named internal events, visible to the checker.
  logic              primed_q;
  logic [STAT_W-1:0] evt_chg;
  logic [STAT_W-1:0] stat;
  logic [STAT_W-1:0] en;
  logic              rd_stat_hit;
  logic              rd_en_hit;
  logic              wr_en_hit;
  logic              irq_hit;
  logic [CHG_KINDS-1:0] port_chg [NPORTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [CHG_KINDS-1:0] lvl;
    assign lvl[EV_LINK]   = link_i[p];
    assign lvl[EV_DUPLEX] = duplex_i[p];
    assign lvl[EV_ANEG]   = aneg_i[p];

    phy_irq_edge #(.KINDS(CHG_KINDS)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .primed_i (primed_q),
      .lvl_i    (lvl),
      .chg_o    (port_chg[p])
    );
  end

  always_comb begin
    evt_chg = '0;
    for (int p = 0; p < NPORTS; p++) begin
      for (int k = 0; k < CHG_KINDS; k++) begin
        evt_chg[stat_bit(p, k)] = port_chg[p][k];
      end
    end
  end

  phy_irq_stat #(
    .NPORTS   (NPORTS),
    .STAT_W   (STAT_W),
    .CHG_MASK (CHG_MASK)
  ) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_chg),
    .jab_i  (jabber_i),
    .clr_i  (rd_stat_hit),
    .stat_o (stat)
  );

  phy_irq_mgmt #(
    .AW         (AW),
    .SEL_W      (SEL_W),
    .DW         (STAT_W),
    .DEV_HI     (DEV_HI),
    .STAT_REGAD (STAT_REGAD),
    .EN_REGAD   (EN_REGAD)
  ) u_mgmt (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_i          (mgmt_rd),
    .wr_i          (mgmt_wr),
    .dev_i         (mgmt_dev),
    .reg_i         (mgmt_reg),
    .wdata_i       (mgmt_wdata),
    .stat_i        (stat),
    .en_o          (en),
    .rdata_o       (mgmt_rdata),
    .rd_stat_hit_o (rd_stat_hit),
    .rd_en_hit_o   (rd_en_hit),
    .wr_en_hit_o   (wr_en_hit)
  );

  // Open-drain style: 1 stands for the released line, 0 for the pulled-down line.
  assign irq_hit = |(stat & en);
  assign irq_n_o = ~irq_hit;

endmodule

// File: rtl/phy_irq_hub_chk.sv
module phy_irq_hub_chk #(
  parameter int NPORTS = 4,
  parameter int STAT_W = 16,
  parameter logic [STAT_W-1:0] CHG_MASK = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [STAT_W-1:0] stat,
  input logic [STAT_W-1:0] en,
  input logic [STAT_W-1:0] evt_chg,
  input logic [NPORTS-1:0] jabber_i,
  input logic              rd_stat_hit,
  input logic              wr_en_hit,
  input logic              irq_n_o
);
  import phy_irq_pkg::*;

  logic              live_q;
  logic [NPORTS-1:0] stat_jab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  always_comb begin
    for (int p = 0; p < NPORTS; p++) stat_jab[p] = stat[stat_bit(p, EV_JABBER)];
  end

  // R2 and R6: every detected change is present in the status word at the next clock, even when a read clears in the same cycle.
  a_r2_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_chg) |=> ((stat & $past(evt_chg)) == $past(evt_chg)));

  // R5: a clearing read with no coincident event leaves no change bit set.
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_hit && (evt_chg == '0)) |=> ((stat & CHG_MASK) == '0));

  // R7: the jabber bits track the jabber inputs one clock later.
  a_r7_jab_follows: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |=> (stat_jab == $past(jabber_i)));

  // R8: the enable word only moves on a matching write.
  a_r8_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !wr_en_hit) |=> $stable(en));

  // R3: with every enable off, the interrupt stays released.
  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> irq_n_o);

  // R4: an enabled change bit keeps the line asserted until a read or an enable write.
  a_r4_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (((stat & en & CHG_MASK) != '0) && !rd_stat_hit && !wr_en_hit) |=> !irq_n_o);

endmodule

bind phy_irq_hub phy_irq_hub_chk #(
  .NPORTS   (NPORTS),
  .STAT_W   (STAT_W),
  .CHG_MASK (CHG_MASK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stat        (stat),
  .en          (en),
  .evt_chg     (evt_chg),
  .jabber_i    (jabber_i),
  .rd_stat_hit (rd_stat_hit),
  .wr_en_hit   (wr_en_hit),
  .irq_n_o     (irq_n_o)
);

// File: tb/phy_irq_hub_test.sv
`timescale 1ns/1ps
module phy_irq_hub_test;

  localparam logic [4:0] STAT_RA = 5'd16;
  localparam logic [4:0] EN_RA   = 5'd21;
  localparam logic [2:0] DEV_HI  = 3'b001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  link_i = 4'b1010;
  logic [3:0]  duplex_i = 4'b0001;
  logic [3:0]  aneg_i = 4'b0110;
  logic [3:0]  jabber_i = 4'b0000;
  logic        mgmt_rd = 1'b0;
  logic        mgmt_wr = 1'b0;
  logic [4:0]  mgmt_dev = '0;
  logic [4:0]  mgmt_reg = '0;
  logic [15:0] mgmt_wdata = '0;
  logic [15:0] mgmt_rdata;
  logic        irq_n_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  phy_irq_hub uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_i     (link_i),
    .duplex_i   (duplex_i),
    .aneg_i     (aneg_i),
    .jabber_i   (jabber_i),
    .mgmt_rd    (mgmt_rd),
    .mgmt_wr    (mgmt_wr),
    .mgmt_dev   (mgmt_dev),
    .mgmt_reg   (mgmt_reg),
    .mgmt_wdata (mgmt_wdata),
    .mgmt_rdata (mgmt_rdata),
    .irq_n_o    (irq_n_o)
  );

  function automatic logic [4:0] dev(input logic [1:0] port);
    return {DEV_HI, port};
  endfunction

  // Driver: one read cycle, expected data goes to the scoreboard.
  task automatic start_read(input logic [4:0] d, input logic [4:0] r,
                            input logic [15:0] exp, input string tag);
    item_t it;
    mgmt_rd  = 1'b1;
    mgmt_dev = d;
    mgmt_reg = r;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic do_read(input logic [4:0] d, input logic [4:0] r,
                         input logic [15:0] exp, input string tag);
    @(negedge clk);
    start_read(d, r, exp, tag);
    @(negedge clk);
    mgmt_rd = 1'b0;
  endtask

  task automatic do_write(input logic [4:0] d, input logic [4:0] r, input logic [15:0] v);
    @(negedge clk);
    mgmt_wr    = 1'b1;
    mgmt_dev   = d;
    mgmt_reg   = r;
    mgmt_wdata = v;
    @(negedge clk);
    mgmt_wr = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    #2;
    checks++;
    if (irq_n_o !== exp) begin
      errors++;
      $display("FAIL %s irq_n_o: got %b expected %b", tag, irq_n_o, exp);
    end
  endtask

  // Monitor: compares read data against the scoreboard, between clock edges.
  always begin
    @(negedge clk);
    #2;
    if (mgmt_rd) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: got %h expected none", mgmt_rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (mgmt_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s rdata: got %h expected %h", it.tag, mgmt_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1, R10: reset state, no spurious event from nonzero input levels.
    chk_irq(1'b1, "R1");
    checks++;
    if (mgmt_rdata !== 16'h0) begin
      errors++;
      $display("FAIL R1 idle rdata: got %h expected 0000", mgmt_rdata);
    end
    do_read(dev(2'd0), EN_RA, 16'h0000, "R1");
    do_read(dev(2'd0), STAT_RA, 16'h0000, "R10");

    // R2, R3, R9: link change on port 1 with enables off, read via an aliased port address.
    @(negedge clk); link_i[1] = ~link_i[1];
    chk_irq(1'b1, "R3");
    do_read(dev(2'd3), STAT_RA, 16'h0010, "R2");
    do_read(dev(2'd0), STAT_RA, 16'h0000, "R5");

    // R4, R5: duplex change on port 2 with all enables set.
    do_write(dev(2'd0), EN_RA, 16'hFFFF);
    @(negedge clk); duplex_i[2] = ~duplex_i[2];
    chk_irq(1'b0, "R4");
    do_read(dev(2'd2), STAT_RA, 16'h0200, "R5");
    chk_irq(1'b1, "R4");

    // R7: jabber on port 3 survives reads, drops with the input.
    @(negedge clk); jabber_i[3] = 1'b1;
    chk_irq(1'b0, "R7");
    do_read(dev(2'd1), STAT_RA, 16'h8000, "R7");
    do_read(dev(2'd1), STAT_RA, 16'h8000, "R7");
    @(negedge clk); jabber_i[3] = 1'b0;
    do_read(dev(2'd1), STAT_RA, 16'h0000, "R7");
    chk_irq(1'b1, "R7");

    // R6: event in the same cycle as a clearing read.
    @(negedge clk); aneg_i[0] = ~aneg_i[0];
    @(negedge clk);
    start_read(dev(2'd0), STAT_RA, 16'h0004, "R6");
    aneg_i[0] = ~aneg_i[0];
    @(negedge clk); mgmt_rd = 1'b0;
    do_read(dev(2'd0), STAT_RA, 16'h0004, "R6");
    do_read(dev(2'd0), STAT_RA, 16'h0000, "R6");

    // R9: foreign device address neither reads nor clears nor writes.
    @(negedge clk); link_i[3] = ~link_i[3];
    do_read(5'b00011, STAT_RA, 16'h0000, "R9");
    do_read(dev(2'd1), STAT_RA, 16'h1000, "R9");
    do_read(dev(2'd1), STAT_RA, 16'h0000, "R9");
    do_write(5'b11000, EN_RA, 16'h0000);
    do_read(dev(2'd2), EN_RA, 16'hFFFF, "R9");

    // R8: write at the status address leaves both words alone.
    do_write(dev(2'd0), STAT_RA, 16'h0000);
    do_read(dev(2'd0), EN_RA, 16'hFFFF, "R8");
    do_read(dev(2'd0), STAT_RA, 16'h0000, "R8");
    do_write(dev(2'd3), EN_RA, 16'h0010);
    do_read(dev(2'd0), EN_RA, 16'h0010, "R8");

    // R4, R3: partial enables gate the line; masked bit still latches.
    @(negedge clk); link_i[0] = ~link_i[0];
    chk_irq(1'b1, "R4");
    @(negedge clk); link_i[1] = ~link_i[1];
    chk_irq(1'b0, "R4");
    do_read(dev(2'd0), STAT_RA, 16'h0011, "R3");
    chk_irq(1'b1, "R4");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule